// File: doc/BRIEF.md
# Dual-Modulus Fractional Clock Divider

This block divides a fast input clock by an integer modulus that can change on every output period. A one-bit modulus-select input picks between a base ratio and that ratio plus one. It sits in the feedback path of a fractional-N synthesizer loop. An upstream sequence generator supplies one select bit per output period. Mixing periods of N and N+1 input cycles gives a fractional average ratio. With a base of 4, the bit patterns 0000, 0001, 0101, 0111 and 1111 give averages of 4, 4.25, 4.5, 4.75 and 5.

The divider is a counter whose terminal count is reloaded at every period boundary. At each boundary the block samples the base ratio and the select bit, computes the terminal values for the coming period, and raises a one-cycle request strobe. The strobe tells the upstream generator to present its next bit. A small state machine shapes the output. `ST_IDLE` is held in reset. `T_RELEASE` moves to `ST_HIGH` on the first edge without reset. `T_HIGH_DONE` moves from `ST_HIGH` to `ST_LOW` when the high half of the period has elapsed. `T_WRAP` moves from `ST_LOW` back to `ST_HIGH` at the terminal count and starts a new period.

Top module: `dmod_frac_divider`

## Requirements
- R1: On every clock edge where `rst` is 1, the block clears its state, so that in the following cycle `clk_div` is 0 and `next_req` is 0.
- R2: A period sampled with `mod_sel` = 0 lasts exactly `base_ratio` input cycles, and one sampled with `mod_sel` = 1 lasts `base_ratio` + 1 cycles.
- R3: `mod_sel` is sampled only on the edge that starts a period. Changes at any other time have no effect on any period.
- R4: The first edge with `rst` at 0 starts the first period, using the `base_ratio` and `mod_sel` present at that edge. In the cycle after that edge, `clk_div` and `next_req` are both 1.
- R5: `next_req` is 1 for exactly one input cycle per period, namely the first cycle of the period, and `clk_div` is 1 in that cycle.
- R6: Within a period of R cycles, `clk_div` is 1 for the first floor(R/2) cycles and 0 for the remaining cycles.
- R7: A `base_ratio` value of 0 or 1 is treated as 2, so the period is 2 or 3 cycles depending on `mod_sel`.
- R8: A repeating select pattern gives the arithmetic average ratio. With base 4, the patterns 0101, 0001 and 0111 take 36, 34 and 38 input cycles over eight periods.
- R9: `base_ratio` is sampled only on the edge that starts a period. Changing it mid-period does not alter the running period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Fast input clock being divided |
| rst | input | 1 | Synchronous reset, active high |
| base_ratio | input | RATIO_W | Integer base ratio (values below 2 act as 2) |
| mod_sel | input | 1 | Modulus select: 0 divides by base, 1 by base plus one |
| clk_div | output | 1 | Divided output clock, high in the first half of each period |
| next_req | output | 1 | One-cycle strobe at each period start asking for the next select bit |

## Verification
If the counter or the latched terminal values are corrupted, the period that is running shows the wrong length. The next `next_req` pulse then arrives early or late, at the next period boundary at the latest. If the state register goes wrong, the high phase ends on the wrong cycle, which shows within the same period as a wrong count of high cycles. If the select latch is wrong, or is sampled on the wrong edge, mid-period changes of the select bit start to stretch or shorten periods. It also shifts the eight-period totals of the fractional patterns away from 34, 36 and 38. The bench measures every period's length and high time at the ports and compares them with values computed from the applied bits.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } fdiv_state_e;

    // Smallest modulus the counter supports; lower base values are raised to it.
    localparam int MIN_RATIO = 2;

endpackage

// File: rtl/fdiv_ratio_reg.sv
module fdiv_ratio_reg
    import fdiv_pkg::*;
#(
    parameter int RATIO_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [RATIO_W-1:0] base,
    input  logic               sel,
    output logic [RATIO_W:0]   term_cnt,
    output logic [RATIO_W:0]   high_last
);

    localparam int CNT_W = RATIO_W + 1;

    logic [CNT_W-1:0] base_eff;
    logic [CNT_W-1:0] ratio_nxt;

    // Effective modulus for the period that starts on this edge.
    always_comb begin
        base_eff = CNT_W'(base);
        if (base_eff < CNT_W'(MIN_RATIO)) begin
            base_eff = CNT_W'(MIN_RATIO);
        end
        ratio_nxt = base_eff + CNT_W'(sel);
    end

    // Terminal values are captured only at a period boundary.
    always_ff @(posedge clk) begin
        if (rst) begin
            term_cnt  <= CNT_W'(MIN_RATIO - 1);
            high_last <= '0;
        end else if (load) begin
            term_cnt  <= ratio_nxt - CNT_W'(1);
            high_last <= (ratio_nxt >> 1) - CNT_W'(1);
        end
    end

endmodule

// File: rtl/fdiv_counter.sv
module fdiv_counter #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    output logic [CNT_W-1:0] cnt
);

    // Index of the current input cycle within the output period.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/fdiv_fsm.sv
module fdiv_fsm
    import fdiv_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] term_cnt,
    input  logic [CNT_W-1:0] high_last,
    output logic             period_start,
    output logic             clk_div,
    output logic             req
);

    fdiv_state_e state_q;
    fdiv_state_e state_d;

    // Next-state and period-start decode.
    always_comb begin
        state_d      = state_q;
        period_start = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                // T_RELEASE
                state_d      = ST_HIGH;
                period_start = 1'b1;
            end
            ST_HIGH: begin
                // T_HIGH_DONE
                if (cnt == high_last) begin
                    state_d = ST_LOW;
                end
            end
            ST_LOW: begin
                // T_WRAP
                if (cnt == term_cnt) begin
                    state_d      = ST_HIGH;
                    period_start = 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs decoded from registered state only.
    always_comb begin
        clk_div = 1'b0;
        req     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                clk_div = 1'b0;
                req     = 1'b0;
            end
            ST_HIGH: begin
                clk_div = 1'b1;
                req     = (cnt == '0);
            end
            ST_LOW: begin
                clk_div = 1'b0;
                req     = 1'b0;
            end
            default: begin
                clk_div = 1'b0;
                req     = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/dmod_frac_divider.sv
module dmod_frac_divider
    import fdiv_pkg::*;
#(
    parameter int RATIO_W = 4
) (
    input  logic               clk_in,
    input  logic               rst,
    input  logic [RATIO_W-1:0] base_ratio,
    input  logic               mod_sel,
    output logic               clk_div,
    output logic               next_req
);

    localparam int CNT_W = RATIO_W + 1;

    logic             period_start;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] term_cnt;
    logic [CNT_W-1:0] high_last;

    fdiv_ratio_reg #(
        .RATIO_W (RATIO_W)
    ) u_ratio (
        .clk       (clk_in),
        .rst       (rst),
        .load      (period_start),
        .base      (base_ratio),
        .sel       (mod_sel),
        .term_cnt  (term_cnt),
        .high_last (high_last)
    );

    fdiv_counter #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk     (clk_in),
        .rst     (rst),
        .restart (period_start),
        .cnt     (cnt)
    );

    fdiv_fsm #(
        .CNT_W (CNT_W)
    ) u_fsm (
        .clk          (clk_in),
        .rst          (rst),
        .cnt          (cnt),
        .term_cnt     (term_cnt),
        .high_last    (high_last),
        .period_start (period_start),
        .clk_div      (clk_div),
        .req          (next_req)
    );

endmodule

// File: rtl/fdiv_chk.sv
module fdiv_chk #(
    parameter int RATIO_W = 4
) (
    input logic               clk_in,
    input logic               rst,
    input logic [RATIO_W-1:0] base_ratio,
    input logic               mod_sel,
    input logic               clk_div,
    input logic               next_req
);

    localparam int CW = RATIO_W + 2;

    logic [CW-1:0] cand_len;
    logic [CW-1:0] per_len;
    logic [CW-1:0] since;
    logic [CW-1:0] hi_cnt;
    logic          have_len;
    logic          rst_seen;

    // Independent model of period length and high time seen at the ports.
    always_ff @(posedge clk_in) begin
        rst_seen <= rst;
        cand_len <= ((base_ratio < RATIO_W'(2)) ? CW'(2) : CW'(base_ratio)) + CW'(mod_sel);
        if (rst) begin
            have_len <= 1'b0;
            per_len  <= '0;
            since    <= '0;
            hi_cnt   <= '0;
        end else if (next_req) begin
            have_len <= 1'b1;
            per_len  <= cand_len;
            since    <= CW'(1);
            hi_cnt   <= CW'(clk_div);
        end else begin
            since    <= since + CW'(1);
            hi_cnt   <= hi_cnt + CW'(clk_div);
        end
    end

    // R1
    always @(negedge clk_in) begin
        if (rst_seen === 1'b1) begin
            quiet_in_reset_chk: assert (clk_div == 1'b0 && next_req == 1'b0);
        end
    end

    // R5
    req_single_chk: assert property (@(posedge clk_in) disable iff (rst)
        next_req |=> !next_req);

    // R5
    req_on_rise_chk: assert property (@(posedge clk_in) disable iff (rst)
        $rose(clk_div) |-> next_req);

    // R5
    req_high_out_chk: assert property (@(posedge clk_in) disable iff (rst)
        next_req |-> clk_div);

    // R2
    period_len_chk: assert property (@(posedge clk_in) disable iff (rst)
        (next_req && have_len) |-> (since == per_len));

    // R6
    high_time_chk: assert property (@(posedge clk_in) disable iff (rst)
        (next_req && have_len) |-> (hi_cnt == (per_len >> 1)));

endmodule

bind dmod_frac_divider fdiv_chk #(
    .RATIO_W (RATIO_W)
) u_fdiv_chk (
    .clk_in     (clk_in),
    .rst        (rst),
    .base_ratio (base_ratio),
    .mod_sel    (mod_sel),
    .clk_div    (clk_div),
    .next_req   (next_req)
);

// File: tb/tb_dmod_frac_divider.sv
`timescale 1ns/1ps
module tb_dmod_frac_divider;

    localparam int RATIO_W = 4;

    logic               clk_in     = 1'b0;
    logic               rst        = 1'b1;
    logic [RATIO_W-1:0] base_ratio = RATIO_W'(4);
    logic               mod_sel    = 1'b0;
    logic               clk_div;
    logic               next_req;

    int checks  = 0;
    int errors  = 0;
    int cur_len = 0;

    always #2.5 clk_in = ~clk_in;

    dmod_frac_divider #(
        .RATIO_W (RATIO_W)
    ) dut (
        .clk_in     (clk_in),
        .rst        (rst),
        .base_ratio (base_ratio),
        .mod_sel    (mod_sel),
        .clk_div    (clk_div),
        .next_req   (next_req)
    );

    function automatic int exp_ratio(input int b, input bit s);
        return ((b < 2) ? 2 : b) + (s ? 1 : 0);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // R1: outputs quiet while reset is applied
    task automatic apply_reset(input int n);
        @(negedge clk_in);
        rst = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk_in);
            check(clk_div == 1'b0, "R1", "clk_div in reset", int'(clk_div), 0);
            check(next_req == 1'b0, "R1", "next_req in reset", int'(next_req), 0);
        end
    endtask

    // R4: first period starts on the release edge with the values present there
    task automatic release_reset(input int b, input bit s);
        @(negedge clk_in);
        rst        = 1'b0;
        base_ratio = b[RATIO_W-1:0];
        mod_sel    = s;
        @(negedge clk_in);
        check(next_req == 1'b1, "R4", "request after release", int'(next_req), 1);
        check(clk_div == 1'b1, "R4", "output after release", int'(clk_div), 1);
        cur_len = exp_ratio(b, s);
    endtask

    // Entered at the negedge of a request cycle. Period 0 is the one already
    // running; periods 1..nper follow the pattern and are summed.
    task automatic run_pattern(input logic [7:0] pat, input int plen, input int nper,
                               input int b, input bit glitch, input int exp_total,
                               input string tag);
        int total;
        total = 0;
        for (int p = 0; p <= nper; p++) begin
            int  len_now;
            int  idx;
            int  high;
            bit  got;
            bit  nxt_s;
            len_now    = cur_len;
            idx        = 0;
            high       = 1;
            got        = 1'b0;
            nxt_s      = pat[p % plen];
            mod_sel    = nxt_s;
            base_ratio = b[RATIO_W-1:0];
            while (!got && idx <= 40) begin
                @(negedge clk_in);
                idx++;
                if (next_req) begin
                    got = 1'b1;
                end else begin
                    high += int'(clk_div);
                    // R3 and R9: disturb select and base away from the boundary
                    if (glitch && len_now >= 3 && idx == 1) begin
                        mod_sel    = ~nxt_s;
                        base_ratio = b[RATIO_W-1:0] ^ RATIO_W'(1);
                    end
                    if (glitch && len_now >= 3 && idx == 2) begin
                        mod_sel    = nxt_s;
                        base_ratio = b[RATIO_W-1:0];
                    end
                end
            end
            check(got, "R5", "request seen", int'(got), 1);
            check(idx == len_now, tag, "period length", idx, len_now);
            check(high == len_now / 2, "R6", "high cycles", high, len_now / 2);
            check(clk_div == 1'b1, "R5", "output high at request", int'(clk_div), 1);
            if (p > 0) total += idx;
            cur_len = exp_ratio(b, nxt_s);
        end
        if (exp_total >= 0) begin
            check(total == exp_total, tag, "pattern total", total, exp_total);
        end
    endtask

    initial begin
        apply_reset(3);
        release_reset(4, 1'b0);
        // R2: fixed modulus both ways
        run_pattern(8'b0000_0000, 1, 4, 4, 1'b0, 16, "R2");
        run_pattern(8'b0000_0001, 1, 4, 4, 1'b0, 20, "R2");
        // R8: fractional averages 4.5, 4.25, 4.75
        run_pattern(8'b0000_0010, 2, 8, 4, 1'b0, 36, "R8");
        // R3: select and base toggled mid-period
        run_pattern(8'b0000_1000, 4, 8, 4, 1'b1, 34, "R3");
        run_pattern(8'b0000_1110, 4, 8, 4, 1'b1, 38, "R8");
        // R7 and R9: sweep every base value with alternating select
        for (int b = 0; b < 16; b++) begin
            run_pattern(8'b0000_0010, 2, 2, b, 1'b1, 2 * exp_ratio(b, 1'b0) + 1,
                        (b < 2) ? "R7" : "R9");
        end
        // R1 and R4: reset in mid-run, release with select 1
        apply_reset(2);
        release_reset(4, 1'b1);
        run_pattern(8'b0000_0000, 1, 2, 4, 1'b0, 8, "R4");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        checks++;
        errors++;
        $display("FAIL R5 watchdog expired: actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule